// File: doc/BRIEF.md
# Cascadable Priority Encoder

This block turns a vector of request lines, several of which may be high together, into the binary index of the single request that has the highest priority. The priority order is fixed. Line 0 ranks lowest and the top line ranks highest. Each basic unit has 2^IDX_W request lines. Inside each unit, a resolution stage first clears every active request except the winning one and exports the result as a one-hot grant vector. A plain binary encoder then turns that grant vector into the index.

Each unit has an enable input and two flags. The any-active flag is high when the unit is enabled and sees at least one request. The pass-down enable is high when the unit is enabled and sees no request. These flags let units be chained. The top module builds a 2^(IDX_W+1)-line encoder from two units. The upper unit takes the external enable. Its pass-down enable drives the lower unit. The upper unit's any-active flag becomes the index MSB. The low index bits are the OR of the two unit indices. The whole path is combinational.

Top module: `prienc_pair`

## Requirements
- R1: When en_i=1 and at least one req_i bit is set, idx_o equals the position of the highest-numbered set bit of req_i.
- R2: When en_i=1 and req_i is all zero, idx_o is 0.
- R3: en_o is 1 exactly when en_i=1 and every req_i bit is 0.
- R4: any_o is 1 exactly when en_i=1 and at least one req_i bit is 1.
- R5: When enabled, grant_o has exactly one bit set, at the position of the highest-numbered set request, whenever any request is set; it is all zero when no request is set.
- R6: When en_i=0, idx_o, grant_o, any_o and en_o are all 0 whatever req_i holds.
- R7: Any request in the upper half (bit index 2^IDX_W or above) outranks every request in the lower half. idx_o bit IDX_W is 1 exactly when the winner lies in the upper half.
- R8: A request on line 0 alone gives idx_o=0 with any_o=1. It is told apart from the no-request case only by any_o and en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | 2^(IDX_W+1) | Request lines, bit 0 lowest priority |
| en_i | input | 1 | Enable for the whole encoder |
| idx_o | output | IDX_W+1 | Index of the winning request |
| grant_o | output | 2^(IDX_W+1) | One-hot copy of the winning request |
| any_o | output | 1 | Enabled and at least one request set |
| en_o | output | 1 | Enabled and no request set; feeds a further stage |

## Verification
The bench builds two instances. The first uses IDX_W=3, which gives a 16-line encoder. With that size every request pattern can be applied with the enable high, so every priority pairing across the two halves is covered, including the half boundary at bit 8. A sample of patterns is also applied with the enable low. The second instance uses IDX_W=5, a 64-line encoder, and takes random patterns with a varying density of set bits. It also takes single-bit walks, so long chains of lower-priority requests behind a winner get covered.

// File: rtl/prienc_pkg.sv
package prienc_pkg;

    // Chaining flags produced by one encoder unit
    typedef struct packed {
        logic any;     // enabled and some request present
        logic pass;    // enabled and no request present
    } prienc_flags_t;

    function automatic prienc_flags_t make_flags(input logic en, input logic some);
        prienc_flags_t f;
        f.any  = en & some;
        f.pass = en & ~some;
        return f;
    endfunction

endpackage

// File: rtl/prienc_resolve.sv
module prienc_resolve #(
    parameter int N = 8
) (
    input  logic [N-1:0] req_i,
    input  logic         en_i,
    output logic [N-1:0] grant_o
);
    logic hit;

    always_comb begin
        hit = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            grant_o[i] = en_i & req_i[i] & ~hit;
            hit        = hit | req_i[i];
        end
    end

    always_comb begin
        // R5
        grant_onehot_chk: assert ($onehot0(grant_o));
        // R5
        grant_subset_chk: assert ((grant_o & ~req_i) == '0);
        // R6
        grant_off_chk: assert (en_i || grant_o == '0);
    end
endmodule

// File: rtl/prienc_encode.sv
module prienc_encode #(
    parameter int IDX_W = 3,
    localparam int N = 1 << IDX_W
) (
    input  logic [N-1:0]     onehot_i,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot_i[i]) idx_o = idx_o | IDX_W'(i);
        end
    end
endmodule

// File: rtl/prienc_unit.sv
module prienc_unit
    import prienc_pkg::*;
#(
    parameter int IDX_W = 3,
    localparam int N = 1 << IDX_W
) (
    input  logic [N-1:0]     req_i,
    input  logic             en_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output prienc_flags_t    flags_o
);
    prienc_resolve #(.N(N)) u_res (
        .req_i  (req_i),
        .en_i   (en_i),
        .grant_o(grant_o)
    );

    prienc_encode #(.IDX_W(IDX_W)) u_enc (
        .onehot_i(grant_o),
        .idx_o   (idx_o)
    );

    assign flags_o = make_flags(en_i, |req_i);

    always_comb begin
        // R3
        flags_excl_chk: assert (!(flags_o.any && flags_o.pass));
        // R4
        any_grant_chk: assert (flags_o.any == (grant_o != '0));
    end
endmodule

// File: rtl/prienc_pair.sv
module prienc_pair
    import prienc_pkg::*;
#(
    parameter int IDX_W = 3,
    localparam int N  = 1 << IDX_W,
    localparam int NW = 2 * N
) (
    input  logic [NW-1:0]  req_i,
    input  logic           en_i,
    output logic [IDX_W:0] idx_o,
    output logic [NW-1:0]  grant_o,
    output logic           any_o,
    output logic           en_o
);
    logic [N-1:0]     g_hi, g_lo;
    logic [IDX_W-1:0] i_hi, i_lo;
    prienc_flags_t    f_hi, f_lo;

    prienc_unit #(.IDX_W(IDX_W)) u_hi (
        .req_i  (req_i[NW-1:N]),
        .en_i   (en_i),
        .grant_o(g_hi),
        .idx_o  (i_hi),
        .flags_o(f_hi)
    );

    prienc_unit #(.IDX_W(IDX_W)) u_lo (
        .req_i  (req_i[N-1:0]),
        .en_i   (f_hi.pass),
        .grant_o(g_lo),
        .idx_o  (i_lo),
        .flags_o(f_lo)
    );

    assign idx_o   = {f_hi.any, i_hi | i_lo};
    assign grant_o = {g_hi, g_lo};
    assign any_o   = f_hi.any | f_lo.any;
    assign en_o    = f_lo.pass;

    always_comb begin
        // R7
        upper_wins_chk: assert (!(f_hi.any && g_lo != '0));
        // R3
        chain_pass_chk: assert (!en_o || (en_i && req_i == '0));
        // R6
        off_quiet_chk: assert (en_i || (!any_o && idx_o == '0));
    end
endmodule

// File: tb/prienc_pair_test.sv
module prienc_pair_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // small instance: 16 lines
    logic [15:0] s_req;
    logic        s_en;
    logic [3:0]  s_idx;
    logic [15:0] s_grant;
    logic        s_any, s_eno;

    prienc_pair #(.IDX_W(3)) uut (
        .req_i(s_req), .en_i(s_en), .idx_o(s_idx),
        .grant_o(s_grant), .any_o(s_any), .en_o(s_eno)
    );

    // large instance: 64 lines
    logic [63:0] b_req;
    logic        b_en;
    logic [5:0]  b_idx;
    logic [63:0] b_grant;
    logic        b_any, b_eno;

    prienc_pair #(.IDX_W(5)) uut_big (
        .req_i(b_req), .en_i(b_en), .idx_o(b_idx),
        .grant_o(b_grant), .any_o(b_any), .en_o(b_eno)
    );

    function automatic int top_bit(input logic [63:0] v);
        int t = -1;
        for (int i = 0; i < 64; i++) if (v[i]) t = i;
        return t;
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // drive at posedge, sample at negedge
    task automatic apply(input bit big, input logic [63:0] r, input logic e);
        int t;
        logic [63:0] eg;
        logic [63:0] ei;
        @(posedge clk);
        if (big) begin b_req = r; b_en = e; end
        else begin s_req = r[15:0]; s_en = e; end
        @(negedge clk);
        t  = top_bit(big ? r : {48'b0, r[15:0]});
        eg = (e && t >= 0) ? (64'b1 << t) : 64'b0;
        ei = (e && t >= 0) ? 64'(t) : 64'b0;
        if (big) begin
            chk(e ? (t >= 0 ? "R1" : "R2") : "R6", 64'(b_idx), ei);
            chk("R5", b_grant, eg);
            chk("R4", 64'(b_any), 64'(e && t >= 0));
            chk("R3", 64'(b_eno), 64'(e && t < 0));
        end else begin
            chk(e ? (t >= 0 ? "R1" : "R2") : "R6", 64'(s_idx), ei);
            chk("R5", 64'(s_grant), eg);
            chk("R4", 64'(s_any), 64'(e && t >= 0));
            chk("R3", 64'(s_eno), 64'(e && t < 0));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        s_req = '0; s_en = 1'b0; b_req = '0; b_en = 1'b0;
        // R6 reset-like idle state
        apply(1'b0, 64'h0, 1'b0);
        // R8 line 0 alone
        apply(1'b0, 64'h1, 1'b1);
        chk("R8", {62'b0, s_any, s_eno}, 64'b10);
        chk("R8", 64'(s_idx), 64'h0);
        // R7 upper half beats lower
        apply(1'b0, 64'h01FF, 1'b1);
        chk("R7", 64'(s_idx), 64'h8);
        apply(1'b0, 64'h00FF, 1'b1);
        chk("R7", 64'(s_idx), 64'h7);
        // R1 R2 R5 exhaustive, enabled
        for (int v = 0; v < 65536; v++) apply(1'b0, 64'(v), 1'b1);
        // R6 disabled sample
        for (int k = 0; k < 1500; k++) apply(1'b0, 64'($urandom), 1'b0);
        // large instance: walking bit and random densities
        for (int i = 0; i < 64; i++) apply(1'b1, 64'b1 << i, 1'b1);
        for (int i = 0; i < 64; i++) apply(1'b1, ~64'b0 >> i, 1'b1);
        apply(1'b1, 64'h0, 1'b1);
        apply(1'b1, ~64'b0, 1'b0);
        for (int k = 0; k < 3000; k++) begin
            r = {$urandom, $urandom};
            case (k % 3)
                0: r = r & {$urandom, $urandom} & {$urandom, $urandom};
                1: r = r >> (k % 64);
                default: ;
            endcase
            apply(1'b1, r, (k % 7) != 0);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule